// File: doc/BRIEF.md
# Unaligned Vector Load Aligner

This block delivers full vectors that start at any byte address in a local scratchpad, even though the scratchpad can only be read one aligned block at a time. A prime command rounds its address down to an alignment boundary and reads the block there. That block goes into an internal holding buffer, and the byte offset of the start address is recorded. No data is returned for a prime.

Each later load command reads the next aligned block. The load joins that block to the held block, shifted by the recorded offset, and emits one full vector. The newly read block then becomes the held state for the following load. After the prime, each vector therefore costs exactly one scratchpad read.

Commands arrive on a single port that carries an operation bit and an address. The scratchpad is reached through a plain read port: an enable and an address go out, and the data comes back on the following cycle. Results leave on a vector bus with a valid strobe and an error strobe. Both strobes appear a fixed number of cycles after the command.

Top module: `valn_aligner`

## Requirements
- R1: A prime command (`cmd_op` = 0) raises `mem_rd_en` in its own cycle, with `mem_rd_addr` equal to `cmd_addr` rounded down to a multiple of ALIGN_BYTES (32 by default).
- R2: A prime command never produces a result: neither `out_valid` nor `out_err` is raised on its behalf.
- R3: Let a stream be primed at byte address A, and let VB be the vector size in bytes (LANES*LANE_W/8). The n-th load of that stream (n counted from 0) outputs the VB scratchpad bytes that start at A + n*VB. Address A+n*VB+i appears in `out_vec[8i+7:8i]`, and byte i of `mem_rd_data` is scratchpad address `mem_rd_addr`+i.
- R4: Each load on a primed stream issues exactly one read, in its own cycle. The read address of the n-th load is the aligned prime address plus (n+1)*VB.
- R5: For every load, `out_valid` or `out_err` is high for exactly one cycle, LATENCY cycles (9 by default) after the command cycle.
- R6: A load (`cmd_op` = 1) that arrives while no stream is primed issues no read. Instead, `out_err` pulses at the normal latency, `out_valid` stays low, and the stream state is unchanged.
- R7: After reset, `out_valid`, `out_err` and `mem_rd_en` are low and no stream is primed.
- R8: A prime may be issued at any time. It discards the held state and restarts the stream at its own address. Loads issued before it still complete with the old stream's data.
- R9: A command may be accepted in every cycle, including a prime followed directly by loads.
- R10: On a load, `cmd_addr` is ignored.
- R11: While `cmd_valid` is low, no read is issued and the stream state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = prime, 1 = load |
| cmd_addr | input | ADDR_W | Byte address, used by prime only |
| mem_rd_en | output | 1 | Scratchpad read request |
| mem_rd_addr | output | ADDR_W | Aligned byte address of the block to read |
| mem_rd_data | input | LANES*LANE_W | Block read, valid the cycle after the request |
| out_valid | output | 1 | Assembled vector present |
| out_vec | output | LANES*LANE_W | Assembled vector, byte 0 in the low bits |
| out_err | output | 1 | Load issued without primed state |

## Verification
The bench targets several corner cases:
- **Offset extremes.** Primes at offset 0 and at offset 31 are tested. A funnel that shifts the wrong way, or takes the wrong half of the joined pair, emits bytes displaced by up to a block.
- **Back-to-back commands.** A prime immediately followed by loads, and a reprime squeezed between loads, are tested. A design that updates the held block or the read pointer one cycle late merges a stale block, or reads the same address twice.
- **Loads with no primed stream.** These are tested right after reset. A faulty design would either read the scratchpad or emit garbage instead of an error pulse.
- **Load addresses.** Random addresses are driven on loads. A design that uses them would read from the wrong place.

// File: rtl/valn_pkg.sv
`timescale 1ns/1ps
package valn_pkg;

    typedef enum logic {
        OP_PRIME = 1'b0,
        OP_LOAD  = 1'b1
    } valn_op_e;

    // Per-command tag carried into the merge stage
    typedef struct packed {
        logic fill;   // a block returns this cycle and replaces the held one
        logic emit;   // a merged vector is produced
        logic err;    // load without primed state
    } valn_tag_t;

    localparam int unsigned VALN_STD_LATENCY = 9;

    function automatic logic cmd_reads(input logic is_prime, input logic is_load,
                                       input logic primed);
        return is_prime | (is_load & primed);
    endfunction

endpackage

// File: rtl/valn_track.sv
`timescale 1ns/1ps
module valn_track
    import valn_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 32,
    parameter int VEC_BYTES   = 256
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  valn_op_e                    cmd_op,
    input  logic [ADDR_W-1:0]           cmd_addr,
    output logic                        rd_en,
    output logic [ADDR_W-1:0]           rd_addr,
    output valn_tag_t                   s1_tag,
    output logic [$clog2(ALIGN_BYTES)-1:0] s1_shift
);
    localparam int SHIFT_W = $clog2(ALIGN_BYTES);

    logic               primed_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic               is_prime, is_load;
    logic [ADDR_W-1:0]  floor_addr;

    assign is_prime   = cmd_valid && (cmd_op == OP_PRIME);
    assign is_load    = cmd_valid && (cmd_op == OP_LOAD);
    assign floor_addr = {cmd_addr[ADDR_W-1:SHIFT_W], {SHIFT_W{1'b0}}};

    always_comb begin
        rd_en   = !rst && cmd_reads(is_prime, is_load, primed_q);
        rd_addr = is_prime ? floor_addr : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            shift_q  <= '0;
            ptr_q    <= '0;
            s1_tag   <= '0;
            s1_shift <= '0;
        end else begin
            s1_tag.fill <= rd_en;
            s1_tag.emit <= is_load && primed_q;
            s1_tag.err  <= is_load && !primed_q;
            s1_shift    <= is_prime ? cmd_addr[SHIFT_W-1:0] : shift_q;
            if (is_prime) begin
                primed_q <= 1'b1;
                shift_q  <= cmd_addr[SHIFT_W-1:0];
                ptr_q    <= floor_addr + ADDR_W'(VEC_BYTES);
            end else if (is_load && primed_q) begin
                ptr_q    <= ptr_q + ADDR_W'(VEC_BYTES);
            end
        end
    end
endmodule

// File: rtl/valn_funnel.sv
`timescale 1ns/1ps
module valn_funnel #(
    parameter int VEC_BYTES   = 256,
    parameter int ALIGN_BYTES = 32
) (
    input  logic [VEC_BYTES*8-1:0]          held_blk,
    input  logic [VEC_BYTES*8-1:0]          fresh_blk,
    input  logic [$clog2(ALIGN_BYTES)-1:0]  shift,
    output logic [VEC_BYTES*8-1:0]          merged
);
    localparam int SHIFT_W = $clog2(ALIGN_BYTES);
    localparam int IDX_W   = $clog2(2 * VEC_BYTES);

    // fresh block holds the higher addresses, so it sits above the held one
    logic [2*VEC_BYTES*8-1:0] joined;
    assign joined = {fresh_blk, held_blk};

    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_byte
        logic [IDX_W-1:0] idx;
        assign idx = IDX_W'(j) + IDX_W'(shift);
        assign merged[j*8 +: 8] = joined[{idx, 3'b000} +: 8];
    end

    // SHIFT_W is referenced so the port width stays tied to it
    if (SHIFT_W < 1) begin : g_bad_align
        initial $display("valn_funnel: ALIGN_BYTES must be at least 2");
    end
endmodule

// File: rtl/valn_delay.sv
`timescale 1ns/1ps
module valn_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[k-1].r;
            end
        end
    end

    assign q = g_stage[DEPTH-1].r;
endmodule

// File: rtl/valn_aligner.sv
`timescale 1ns/1ps
module valn_aligner
    import valn_pkg::*;
#(
    parameter int LANES       = 64,
    parameter int LANE_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 32,
    parameter int LATENCY     = VALN_STD_LATENCY
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic                      cmd_op,
    input  logic [ADDR_W-1:0]         cmd_addr,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    input  logic [LANES*LANE_W-1:0]   mem_rd_data,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_vec,
    output logic                      out_err
);
    localparam int VEC_W     = LANES * LANE_W;
    localparam int VEC_BYTES = VEC_W / 8;
    localparam int SHIFT_W   = $clog2(ALIGN_BYTES);
    localparam int DEPTH     = LATENCY - 1;   // merge stage supplies one cycle

    valn_op_e           op_e;
    valn_tag_t          s1_tag;
    logic [SHIFT_W-1:0] s1_shift;
    logic [VEC_W-1:0]   held_q;
    logic [VEC_W-1:0]   merged;
    logic [VEC_W+1:0]   pipe_d, pipe_q;

    assign op_e = valn_op_e'(cmd_op);

    valn_track #(
        .ADDR_W      (ADDR_W),
        .ALIGN_BYTES (ALIGN_BYTES),
        .VEC_BYTES   (VEC_BYTES)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e),
        .cmd_addr  (cmd_addr),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .s1_tag    (s1_tag),
        .s1_shift  (s1_shift)
    );

    // Held block: replaced by every block that returns
    always_ff @(posedge clk) begin
        if (rst)              held_q <= '0;
        else if (s1_tag.fill) held_q <= mem_rd_data;
    end

    valn_funnel #(
        .VEC_BYTES   (VEC_BYTES),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_funnel (
        .held_blk  (held_q),
        .fresh_blk (mem_rd_data),
        .shift     (s1_shift),
        .merged    (merged)
    );

    assign pipe_d = {s1_tag.emit, s1_tag.err, s1_tag.emit ? merged : '0};

    valn_delay #(
        .WIDTH (VEC_W + 2),
        .DEPTH (DEPTH)
    ) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (pipe_d),
        .q   (pipe_q)
    );

    assign out_valid = pipe_q[VEC_W+1];
    assign out_err   = pipe_q[VEC_W];
    assign out_vec   = pipe_q[VEC_W-1:0];
endmodule

// File: rtl/valn_aligner_chk.sv
`timescale 1ns/1ps
module valn_aligner_chk #(
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 32,
    parameter int VEC_BYTES   = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              out_valid,
    input logic              out_err
);
    localparam int SHIFT_W = $clog2(ALIGN_BYTES);

    logic seen_prime;
    always_ff @(posedge clk) begin
        if (rst)                         seen_prime <= 1'b0;
        else if (cmd_valid && !cmd_op)   seen_prime <= 1'b1;
    end

    AST_PRIME_FLOOR_READ: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_op) |-> (mem_rd_en && mem_rd_addr[SHIFT_W-1:0] == '0
            && mem_rd_addr + ADDR_W'(cmd_addr[SHIFT_W-1:0]) == cmd_addr)); // R1

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !mem_rd_en); // R11

    AST_LOAD_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op && mem_rd_en && $past(cmd_valid && cmd_op && mem_rd_en))
            |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(VEC_BYTES))); // R4

    AST_UNPRIMED_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op && !seen_prime) |-> !mem_rd_en); // R6

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({out_valid, out_err}) <= 1); // R5
endmodule

bind valn_aligner valn_aligner_chk #(
    .ADDR_W      (ADDR_W),
    .ALIGN_BYTES (ALIGN_BYTES),
    .VEC_BYTES   (VEC_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .out_valid   (out_valid),
    .out_err     (out_err)
);

// File: tb/sim_valn_aligner.sv
`timescale 1ns/1ps
module sim_valn_aligner;
    localparam int LANES  = 64;
    localparam int LANE_W = 32;
    localparam int ALIGN  = 32;
    localparam int LAT    = 9;
    localparam int VB     = LANES * LANE_W / 8;
    localparam int VW     = VB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [31:0]   cmd_addr = '0;
    logic          mem_rd_en;
    logic [31:0]   mem_rd_addr;
    logic [VW-1:0] mem_rd_data = '0;
    logic          out_valid, out_err;
    logic [VW-1:0] out_vec;

    always #2 clk = ~clk;   // 250 MHz

    valn_aligner u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_vec(out_vec),
        .out_err(out_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string phase = "init";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return a[7:0] * 8'd7 + a[15:8] + 8'd3;
    endfunction

    function automatic logic [VW-1:0] span(input logic [31:0] a);
        logic [VW-1:0] v;
        for (int i = 0; i < VB; i++) v[i*8 +: 8] = byte_at(a + 32'(i));
        return v;
    endfunction

    // scratchpad model: one-cycle read
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= span(mem_rd_addr);

    // expectation queues
    int            due_q[$];
    bit            emit_q[$];
    logic [VW-1:0] vec_q[$];
    string         tag_q[$];

    // reference stream model
    bit          m_primed = 1'b0;
    logic [31:0] m_start  = '0;
    logic [31:0] m_ptr    = '0;

    task automatic chk(input bit ok, input string msg,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic observe();
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            if (emit_q[0]) begin
                chk(out_valid && !out_err, {tag_q[0], " R5 valid strobe at latency"},
                    VW'({out_valid, out_err}), VW'(2'b10));
                chk(out_vec == vec_q[0], {tag_q[0], " R3 assembled vector"},
                    out_vec, vec_q[0]);
            end else begin
                chk(out_err && !out_valid, {tag_q[0], " R6 error strobe"},
                    VW'({out_valid, out_err}), VW'(2'b01));
            end
            void'(due_q.pop_front());
            void'(emit_q.pop_front());
            void'(vec_q.pop_front());
            void'(tag_q.pop_front());
        end else begin
            chk(!out_valid && !out_err, {phase, " R2 R5 no unexpected result"},
                VW'({out_valid, out_err}), VW'(0));
        end
    endtask

    task automatic issue(input bit v, input bit op, input logic [31:0] a);
        @(negedge clk);
        observe();
        cmd_valid = v;
        cmd_op    = op;
        cmd_addr  = a;
        #1;
        if (!v) begin
            chk(!mem_rd_en, {phase, " R11 idle issues no read"}, VW'(mem_rd_en), VW'(0));
        end else if (!op) begin
            chk(mem_rd_en && mem_rd_addr == (a & ~32'(ALIGN - 1)),
                {phase, " R1 prime reads floor block"},
                VW'({mem_rd_en, mem_rd_addr}), VW'({1'b1, a & ~32'(ALIGN - 1)}));
            m_primed = 1'b1;
            m_start  = a;
            m_ptr    = (a & ~32'(ALIGN - 1)) + 32'(VB);
        end else if (!m_primed) begin
            chk(!mem_rd_en, {phase, " R6 unprimed load issues no read"},
                VW'(mem_rd_en), VW'(0));
            due_q.push_back(cyc + LAT); emit_q.push_back(1'b0);
            vec_q.push_back('0);        tag_q.push_back(phase);
        end else begin
            chk(mem_rd_en && mem_rd_addr == m_ptr, {phase, " R4 R10 load reads next block"},
                VW'({mem_rd_en, mem_rd_addr}), VW'({1'b1, m_ptr}));
            due_q.push_back(cyc + LAT); emit_q.push_back(1'b1);
            vec_q.push_back(span(m_start)); tag_q.push_back(phase);
            m_start = m_start + 32'(VB);
            m_ptr   = m_ptr + 32'(VB);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd9173));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        phase = "R7";
        chk(!out_valid && !out_err && !mem_rd_en, "R7 reset outputs low",
            VW'({out_valid, out_err, mem_rd_en}), VW'(0));
        issue(1, 1, 32'h0000_0040);   // R7 R6: load before any prime
        issue(1, 1, 32'h0000_0000);
        issue(0, 0, 32'h0);

        phase = "R9";                 // aligned prime, loads every cycle
        issue(1, 0, 32'h0000_1000);
        issue(1, 1, 32'h0000_0000);
        issue(1, 1, 32'h0000_0000);
        issue(1, 1, 32'h0000_0000);

        phase = "R3";                 // largest offset, with gaps
        issue(1, 0, 32'h0002_001F);
        issue(0, 0, 32'h0);
        issue(1, 1, 32'h0000_0000);
        issue(0, 0, 32'h0);
        issue(0, 0, 32'h0);
        issue(1, 1, 32'h0000_0000);

        phase = "R8";                 // reprime between back-to-back loads
        issue(1, 0, 32'h0000_3005);
        issue(1, 1, 32'h0000_0000);
        issue(1, 0, 32'h0000_4011);
        issue(1, 1, 32'h0000_0000);
        issue(1, 0, 32'h0000_5001);
        issue(1, 0, 32'h0000_600C);
        issue(1, 1, 32'h0000_0000);

        phase = "R10";                // load addresses are noise
        issue(1, 1, 32'hDEAD_BEEF);
        issue(1, 1, 32'h0000_0013);

        phase = "rand";
        for (int n = 0; n < 300; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2)      issue(1, 0, $urandom & 32'h000F_FFFF);
            else if (r < 8) issue(1, 1, $urandom);
            else            issue(0, 0, $urandom);
        end

        phase = "drain";
        for (int n = 0; n < LAT + 2; n++) issue(0, 0, 32'h0);
        chk(due_q.size() == 0, "R5 every load produced a result",
            VW'(due_q.size()), VW'(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule